// File: doc/BRIEF.md
# ADC Conversion Result Queue Read Port

This block holds ADC conversion results in a small first-in first-out queue and hands them to a processor through a memory-mapped read window. The converter side offers one result per cycle, each made of a 12-bit conversion value and a 5-bit input channel number. On the bus side, every word-aligned read that lands anywhere in a 32-byte window removes the oldest result and returns it packed into a 32-bit word. Because all eight word addresses in the window alias the same queue head, a burst of eight word reads drains up to eight results.

The layout of the returned word depends on a resolution input, which selects 12-bit or 10-bit packing, and on a channel-id enable, which chooses between reporting the channel number and forcing that field to zero. Both inputs are sampled on the read strobe. A read that finds the queue empty returns a word with the empty flag set and leaves the queue untouched. A push into a full queue is dropped, and a sticky overrun output records the loss.

Top module: `adc_result_fifo_port`

## Requirements
- R1: A read with `rd_en` high at a byte address from 0xD0 to 0xEC with address bits 1:0 equal to zero removes exactly one result from a non-empty queue; results come out in the order they were pushed, whichever of the eight aliases is used.
- R2: With `res_10bit` low, a read of a stored result returns bit 31 = 0, bits 20:16 = channel, bits 11:0 = 12-bit value, and all other bits zero.
- R3: With `res_10bit` high, a read of a stored result returns bits 31:16 = 0, bit 15 = 0, bits 14:10 = channel, and bits 9:0 = the low ten bits of the value.
- R4: A window read while the queue is empty returns only the empty flag set (bit 31 in 12-bit packing, bit 15 in 10-bit packing), all other bits zero, and changes no queue pointer or count.
- R5: The first window read after reset, with no push in between, returns the empty flag set.
- R6: With `chan_id_en` low at the read, the channel field of the returned word is zero; with it high, the field is the pushed channel number (0 to 31).
- R7: A push into a queue holding `DEPTH` results (default 16), with no pop in the same cycle, is discarded, and `overrun` goes high one cycle later and stays high until reset.
- R8: A push and a pop in the same cycle are both accepted and the stored count is unchanged, including when the queue is full.
- R9: `rd_data` changes only in the cycle after a read strobe and holds its value otherwise; it is zero after reset.
- R10: A read with `rd_en` high whose address is outside 0xD0–0xEF or not word-aligned returns zero and removes no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Converter offers a result this cycle |
| push_value | input | 12 | Conversion value |
| push_chan | input | 5 | Input channel of the conversion |
| res_10bit | input | 1 | 1 selects 10-bit packing, 0 selects 12-bit |
| chan_id_en | input | 1 | 1 reports the channel, 0 forces it to zero |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W (8) | Byte address of the read |
| rd_data | output | 32 | Packed read word, valid the cycle after the strobe |
| overrun | output | 1 | Sticky flag: a result was dropped on a full queue |

## Verification
The bench drives reads through every alias in the window, at misaligned offsets and just outside both edges, so that a wrong address decode shows up either as a lost pop or as a stray one in the reference queue. Each stored result is read back under both packings and both channel-id settings, with channel and value patterns chosen so that a shifted or swapped field changes the word. Reads on an empty queue, pushes on a full one and simultaneous push and pop at both ends of the count tell the pointer and count logic apart from a design that merely packs data correctly.

// File: rtl/adc_result_fifo_port.sv
module adc_result_fifo_port #(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 8'hD0,
  parameter logic [ADDR_W-1:0] WIN_HI = 8'hEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [11:0]       push_value,
  input  logic [4:0]        push_chan,
  input  logic              res_10bit,
  input  logic              chan_id_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [11:0]   val_q [DEPTH];
  logic [4:0]    chan_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  wire hit     = rd_en && (rd_addr[1:0] == 2'b00) && (rd_addr >= WIN_LO) && (rd_addr <= WIN_HI);
  wire is_empty = (count == '0);
  wire do_pop  = hit && !is_empty;
  wire do_push = push_valid && ((count != FULL) || do_pop);

  wire [11:0] head_val  = val_q[rd_ptr];
  wire [4:0]  head_chan = chan_id_en ? chan_q[rd_ptr] : 5'd0;
  wire [11:0] out_val   = is_empty ? 12'd0 : head_val;
  wire [4:0]  out_chan  = is_empty ? 5'd0 : head_chan;

  wire [31:0] word12 = {is_empty, 10'd0, out_chan, 4'd0, out_val};
  wire [31:0] word10 = {16'd0, is_empty, out_chan, out_val[9:0]};

  always_ff @(posedge clk) begin
    if (do_push) begin
      val_q[wr_ptr]  <= push_value;
      chan_q[wr_ptr] <= push_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
      rd_data <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (push_valid && !do_push) overrun <= 1'b1;
      if (rd_en) rd_data <= !hit ? 32'd0 : (res_10bit ? word10 : word12);
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && count == FULL && !hit) |=> (overrun && count == FULL));

  a_r4_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && is_empty) |=> (rd_ptr == $past(rd_ptr)));

  a_r8_push_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && hit && !is_empty) |=> $stable(count));

  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rd_data == 32'd0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/test_adc_result_fifo_port.sv
module test_adc_result_fifo_port;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [11:0] push_value = '0;
  logic [4:0]  push_chan = '0;
  logic        res_10bit = 1'b0;
  logic        chan_id_en = 1'b1;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        overrun;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct { logic [11:0] v; logic [4:0] c; } ent_t;
  ent_t q[$];
  logic [31:0] exp_data = '0;
  logic        exp_ovr = 1'b0;

  always #4 clk = ~clk;

  adc_result_fifo_port i_adc_result_fifo_port (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_value(push_value),
    .push_chan(push_chan), .res_10bit(res_10bit), .chan_id_en(chan_id_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .overrun(overrun));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit pv, input logic [11:0] pval,
                      input logic [4:0] pch, input bit re, input logic [7:0] ra,
                      input bit m10, input bit cen);
    bit hit;
    ent_t e;
    push_valid = pv; push_value = pval; push_chan = pch;
    rd_en = re; rd_addr = ra; res_10bit = m10; chan_id_en = cen;
    hit = re && ra[1:0] == 2'b00 && ra >= 8'hD0 && ra <= 8'hEF;
    if (re) begin
      if (!hit) exp_data = 32'd0;
      else if (q.size() == 0) exp_data = m10 ? 32'h0000_8000 : 32'h8000_0000;
      else begin
        e = q.pop_front();
        if (!cen) e.c = 5'd0;
        exp_data = m10 ? {16'd0, 1'b0, e.c, e.v[9:0]} : {1'b0, 10'd0, e.c, 4'd0, e.v};
      end
    end
    if (pv) begin
      if (q.size() < DEPTH) q.push_back('{pval, pch});
      else exp_ovr = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " rd_data"}, rd_data, exp_data);
    check({tag, " overrun"}, {31'd0, overrun}, {31'd0, exp_ovr});
    push_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic push(input string tag, input logic [11:0] v, input logic [4:0] c);
    step(tag, 1'b1, v, c, 1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input bit m10, input bit cen);
    step(tag, 1'b0, 12'h0, 5'h0, 1'b1, a, m10, cen);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset rd_data", rd_data, 32'd0);
    check("R7 reset overrun", {31'd0, overrun}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    rd("R5 first read empty 12b", 8'hD0, 1'b0, 1'b1);
    rd("R4 empty read 10b", 8'hEC, 1'b1, 1'b1);
    rd("R4 empty read again", 8'hD8, 1'b0, 1'b0);

    push("R1 push", 12'hABC, 5'd21);
    push("R1 push", 12'h5F3, 5'd10);
    push("R1 push", 12'hFFF, 5'd31);
    push("R1 push", 12'h001, 5'd1);
    rd("R2 12b chid on", 8'hD0, 1'b0, 1'b1);
    rd("R3 10b chid on", 8'hE4, 1'b1, 1'b1);
    rd("R6 12b chid off", 8'hDC, 1'b0, 1'b0);
    rd("R6 10b chid off", 8'hEC, 1'b1, 1'b0);
    rd("R4 drained", 8'hE0, 1'b1, 1'b1);

    push("R10 push", 12'h123, 5'd7);
    rd("R10 misaligned", 8'hD1, 1'b0, 1'b1);
    rd("R10 misaligned 2", 8'hEE, 1'b0, 1'b1);
    rd("R10 below window", 8'hCC, 1'b0, 1'b1);
    rd("R10 above window", 8'hF0, 1'b0, 1'b1);
    step("R9 idle hold", 1'b0, 12'h0, 5'h0, 1'b0, 8'hD0, 1'b0, 1'b1);
    rd("R10 entry kept", 8'hEC, 1'b0, 1'b1);
    step("R9 idle hold", 1'b0, 12'h0, 5'h0, 1'b0, 8'hD0, 1'b1, 1'b1);

    for (int i = 0; i < 8; i++) push("R1 burst push", 12'(12'h300 + 37 * i), 5'(3 * i + 2));
    for (int i = 0; i < 8; i++) rd("R1 burst alias", 8'(8'hD0 + 4 * i), i[0], 1'b1);
    rd("R4 after burst", 8'hD4, 1'b0, 1'b1);

    step("R8 push+pop empty", 1'b1, 12'h777, 5'd9, 1'b1, 8'hD0, 1'b0, 1'b1);
    step("R8 push+pop one", 1'b1, 12'h888, 5'd11, 1'b1, 8'hD8, 1'b0, 1'b1);
    rd("R8 survivor", 8'hE8, 1'b0, 1'b1);

    for (int i = 0; i < DEPTH; i++) push("R7 fill", 12'(12'h800 + i), 5'(i));
    push("R7 drop", 12'hDEA, 5'd30);
    step("R8 push+pop full", 1'b1, 12'h4A5, 5'd19, 1'b1, 8'hE0, 1'b1, 1'b1);
    push("R7 drop again", 12'hBAD, 5'd29);
    for (int i = 0; i < DEPTH; i++) rd("R7 drain order", 8'(8'hD0 + 4 * (i % 8)), 1'b0, 1'b1);
    rd("R4 empty after drain", 8'hD0, 1'b1, 1'b1);

    rst_n = 1'b0;
    @(negedge clk);
    q.delete(); exp_data = '0; exp_ovr = 1'b0;
    check("R7 overrun cleared", {31'd0, overrun}, 32'd0);
    check("R9 rd_data cleared", rd_data, 32'd0);
    rst_n = 1'b1;
    rd("R5 empty after reset", 8'hDC, 1'b0, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule